// File: doc/BRIEF.md
# Divided Skewed Clock Bank

This block produces the logical waveform of one clock output bank. It runs on a fast tick clock in which every tick is one skew time unit (tU) of the oscillator period. One oscillator period is 16 tU in the slow ranges and 8 tU in the fast range. The block divides that period by an integer from 1 to 32. It can invert the divided clock, and it shifts the divided clock by a signed number of tU. The set of shifts the bank accepts depends on whether its index is odd or even.

A synchronous enable gates the bank. The enable is taken only at the start of a divided cycle, so no partial pulse reaches the outputs. While the bank is disabled it holds its outputs low, holds them high, or drives low with the high-impedance flag raised. Reset also serves as power-down. Leaving it restarts the phase counter from zero, so every bank built from this block comes out of reset aligned with the reference. The two output bits are separately registered copies of the same clock.

Top module: `clk_bank_out`

## Requirements
- R1: While `rst` is high, after each clock edge `bank_q` is 0 and `oe_n` is 1.
- R2: With `fast_rng`=0, the divided period is `div_sel`×16 ticks and the output is high for the first half of it. On the first edge after reset the output takes the value for phase position 0.
- R3: With `fast_rng`=1, the divided period is `div_sel`×8 ticks, with the same half-high shape.
- R4: A `div_sel` of 0 acts as 1, and any value above 32 acts as 32.
- R5: With `inv_en`=1, the enabled output is the divided clock inverted. The inversion is applied after division.
- R6: `skew` is a 4-bit two's-complement count of tU. A positive value delays the bank waveform by that many ticks. A negative value advances it, which is implemented as a delay of period−|skew| within the divided period.
- R7: An odd `BANK_IDX` accepts skews from −4 to +4. An even `BANK_IDX` accepts −6, −4, −2, −1, 0, 1, 2, 4 and 6. Any other value acts as 0.
- R8: `out_en` is sampled only on the tick where the skewed phase position is 0. The sampled value governs the whole divided cycle that follows, so output pulses are always whole.
- R9: While the bank is disabled, `dis_mode` selects the outputs: 0 or 3 drives 0, 1 drives 1, and 2 drives 0 with `oe_n`=1. `oe_n` is 0 in every other case. The mode applies from the next clock edge.
- R10: A reset pulse in the middle of a run realigns the waveform. The sequence after reset is the same as after the first reset.
- R11: Both bits of `bank_q` always carry the same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock, one tU per cycle |
| rst | input | 1 | Synchronous active-high reset and power-down |
| fast_rng | input | 1 | 1 selects 8 tU per oscillator period, 0 selects 16 |
| div_sel | input | 6 | Divide value, 1 to 32 |
| inv_en | input | 1 | Invert the divided clock |
| skew | input | 4 | Signed phase offset in tU |
| out_en | input | 1 | Synchronous output enable |
| dis_mode | input | 2 | Level used while disabled (low, high, high-Z) |
| bank_q | output | 2 | Two identical bank clock bits |
| oe_n | output | 1 | High when the bank is in high-Z |

## Verification
The hardest case to reach is an enable change that lands in the middle of a skewed divided cycle. The change must not take effect until the skewed phase wraps, and that point moves with skew, parity and division. The stimulus drops and raises `out_en` a few ticks into cycles with nonzero skew. It runs two instances side by side, one with odd `BANK_IDX` and one with even, on the same inputs. Skews that are legal for one parity and illegal for the other, such as 3 and 6, are applied to both instances. The scoreboard's tick-by-tick prediction therefore separates the two instances exactly where R7 says they differ.

// File: rtl/cbk_pkg.sv
package cbk_pkg;
  typedef enum logic [1:0] {
    DIS_LOW  = 2'd0,
    DIS_HIGH = 2'd1,
    DIS_HIZ  = 2'd2,
    DIS_RSV  = 2'd3
  } dis_mode_e;
endpackage

// File: rtl/cbk_skew_sel.sv
// Replaces a skew that is not legal for this bank's parity with zero.
module cbk_skew_sel #(
  parameter int BANK_IDX = 0,
  parameter int SKW      = 4
) (
  input  logic [SKW-1:0] skew_in,
  output logic [SKW-1:0] skew_ok
);
  logic signed [SKW-1:0] s;
  logic                  legal;

  assign s = skew_in;

  generate
    if (BANK_IDX % 2 == 1) begin : g_odd
      assign legal = (s >= -4) && (s <= 4);
    end else begin : g_even
      assign legal = s inside {-6, -4, -2, -1, 0, 1, 2, 4, 6};
    end
  endgenerate

  assign skew_ok = legal ? skew_in : '0;
endmodule

// File: rtl/cbk_phase_ctr.sv
// Free-running position inside the divided period, shifted by the skew.
module cbk_phase_ctr #(
  parameter int MAX_DIV = 32,
  parameter int TU_LO   = 16,
  parameter int TU_HI   = 8,
  parameter int SKW     = 4,
  localparam int DW     = $clog2(MAX_DIV + 1),
  localparam int PW     = $clog2(MAX_DIV * TU_LO) + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           fast_rng,
  input  logic [DW-1:0]  div_in,
  input  logic [SKW-1:0] skew,
  output logic [PW-1:0]  pos,
  output logic [PW-1:0]  half
);
  logic [DW-1:0]  div_c;
  logic [PW-1:0]  per;
  logic [PW-1:0]  dly;
  logic [SKW-1:0] mag;
  logic [PW-1:0]  cnt;

  always_comb begin
    if (div_in == '0)                 div_c = DW'(1);
    else if (div_in > DW'(MAX_DIV))   div_c = DW'(MAX_DIV);
    else                              div_c = div_in;
  end

  assign per  = PW'(div_c) * (fast_rng ? PW'(TU_HI) : PW'(TU_LO));
  assign half = per >> 1;
  assign mag  = skew[SKW-1] ? (~skew + 1'b1) : skew;
  assign dly  = skew[SKW-1] ? (per - PW'(mag)) : PW'(mag);
  assign pos  = (cnt >= dly) ? (cnt - dly) : (cnt + per - dly);

  always_ff @(posedge clk) begin
    if (rst)                 cnt <= '0;
    else if (cnt >= per - 1) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cbk_out_stage.sv
// Boundary-sampled enable, disable levels and the registered output copies.
module cbk_out_stage
  import cbk_pkg::*;
#(
  parameter int PW      = 10,
  parameter int NUM_OUT = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PW-1:0]      pos,
  input  logic [PW-1:0]      half,
  input  logic               inv_en,
  input  logic               out_en,
  input  logic [1:0]         dis_mode,
  output logic [NUM_OUT-1:0] bank_q,
  output logic               oe_n,
  output logic               en_state
);
  dis_mode_e dm;
  logic      en_eff;
  logic      val;
  logic      hiz;

  assign dm     = dis_mode_e'(dis_mode);
  assign en_eff = (pos == '0) ? out_en : en_state;
  assign val    = en_eff ? ((pos < half) ^ inv_en) : (dm == DIS_HIGH);
  assign hiz    = !en_eff && (dm == DIS_HIZ);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_state <= 1'b0;
      oe_n     <= 1'b1;
    end else begin
      en_state <= en_eff;
      oe_n     <= hiz;
    end
  end

  generate
    for (genvar i = 0; i < NUM_OUT; i++) begin : g_copy
      always_ff @(posedge clk) begin
        if (rst) bank_q[i] <= 1'b0;
        else     bank_q[i] <= val;
      end
    end
  endgenerate
endmodule

// File: rtl/clk_bank_out.sv
module clk_bank_out #(
  parameter int BANK_IDX = 0,
  parameter int MAX_DIV  = 32,
  parameter int TU_LO    = 16,
  parameter int TU_HI    = 8,
  parameter int SKW      = 4,
  parameter int NUM_OUT  = 2,
  localparam int DW      = $clog2(MAX_DIV + 1),
  localparam int PW      = $clog2(MAX_DIV * TU_LO) + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fast_rng,
  input  logic [DW-1:0]      div_sel,
  input  logic               inv_en,
  input  logic [SKW-1:0]     skew,
  input  logic               out_en,
  input  logic [1:0]         dis_mode,
  output logic [NUM_OUT-1:0] bank_q,
  output logic               oe_n
);
  logic [SKW-1:0] skew_ok;
  logic [PW-1:0]  pos;
  logic [PW-1:0]  half;
  logic           en_state;

  cbk_skew_sel #(.BANK_IDX(BANK_IDX), .SKW(SKW)) u_skew (
    .skew_in(skew),
    .skew_ok(skew_ok)
  );

  cbk_phase_ctr #(.MAX_DIV(MAX_DIV), .TU_LO(TU_LO), .TU_HI(TU_HI), .SKW(SKW)) u_ph (
    .clk(clk),
    .rst(rst),
    .fast_rng(fast_rng),
    .div_in(div_sel),
    .skew(skew_ok),
    .pos(pos),
    .half(half)
  );

  cbk_out_stage #(.PW(PW), .NUM_OUT(NUM_OUT)) u_out (
    .clk(clk),
    .rst(rst),
    .pos(pos),
    .half(half),
    .inv_en(inv_en),
    .out_en(out_en),
    .dis_mode(dis_mode),
    .bank_q(bank_q),
    .oe_n(oe_n),
    .en_state(en_state)
  );
endmodule

// File: rtl/clk_bank_out_chk.sv
module clk_bank_out_chk #(
  parameter int NUM_OUT = 2,
  parameter int PW      = 10
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_OUT-1:0] bank_q,
  input logic               oe_n,
  input logic               inv_en,
  input logic               en_q,
  input logic [PW-1:0]      pos
);
  // R11
  copies_match_chk: assert property (@(posedge clk) disable iff (rst)
    bank_q == {NUM_OUT{bank_q[0]}});

  // R9
  hiz_drives_low_chk: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> (bank_q == '0));

  // R8
  enable_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(en_q)) |-> ($past(pos) == '0));

  // R6
  rise_at_phase_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (en_q && !$past(inv_en) && $rose(bank_q[0])) |-> ($past(pos) == '0));
endmodule

bind clk_bank_out clk_bank_out_chk #(.NUM_OUT(NUM_OUT), .PW(PW)) u_chk (
  .clk(clk),
  .rst(rst),
  .bank_q(bank_q),
  .oe_n(oe_n),
  .inv_en(inv_en),
  .en_q(en_state),
  .pos(pos)
);

// File: tb/tb_clk_bank_out.sv
`timescale 1ns/1ps
module tb_clk_bank_out;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fast_rng = 1'b0;
  logic [5:0] div_sel = 6'd1;
  logic       inv_en = 1'b0;
  logic [3:0] skew = 4'd0;
  logic       out_en = 1'b1;
  logic [1:0] dis_mode = 2'd0;
  logic [1:0] q_e, q_o;
  logic       z_e, z_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct {
    string tag;
    bit    v [2];
    bit    z [2];
  } exp_t;
  exp_t sbq[$];

  int mcnt [2];
  bit men [2];

  always #2.5 clk = ~clk;

  clk_bank_out #(.BANK_IDX(0)) dut (
    .clk(clk), .rst(rst), .fast_rng(fast_rng), .div_sel(div_sel), .inv_en(inv_en),
    .skew(skew), .out_en(out_en), .dis_mode(dis_mode), .bank_q(q_e), .oe_n(z_e));

  clk_bank_out #(.BANK_IDX(1)) dut_odd (
    .clk(clk), .rst(rst), .fast_rng(fast_rng), .div_sel(div_sel), .inv_en(inv_en),
    .skew(skew), .out_en(out_en), .dis_mode(dis_mode), .bank_q(q_o), .oe_n(z_o));

  // R7: legal skew sets per parity
  function automatic int legal_skew(int par, int s);
    if (par == 1) return (s >= -4 && s <= 4) ? s : 0;
    if (s == -6 || s == -4 || s == -2 || s == -1 || s == 0 ||
        s == 1 || s == 2 || s == 4 || s == 6) return s;
    return 0;
  endfunction

  // Driver: predicts the outputs after the next clock edge and queues them.
  task automatic step(string tag);
    exp_t e;
    int dc, per, s, d, p;
    bit ee;
    e.tag = tag;
    for (int i = 0; i < 2; i++) begin
      if (rst) begin
        e.v[i] = 0; e.z[i] = 1; mcnt[i] = 0; men[i] = 0;
      end else begin
        dc  = (div_sel == 0) ? 1 : ((div_sel > 32) ? 32 : int'(div_sel));
        per = dc * (fast_rng ? 8 : 16);
        s   = legal_skew(i, int'($signed(skew)));
        d   = (s < 0) ? per + s : s;
        p   = (mcnt[i] - d + per) % per;
        ee  = (p == 0) ? out_en : men[i];
        e.v[i] = ee ? ((p < per / 2) ^ inv_en) : (dis_mode == 2'd1);
        e.z[i] = !ee && (dis_mode == 2'd2);
        men[i]  = ee;
        mcnt[i] = (mcnt[i] >= per - 1) ? 0 : mcnt[i] + 1;
      end
    end
    sbq.push_back(e);
  endtask

  task automatic run(string tag, int n);
    repeat (n) begin
      step(tag);
      @(negedge clk);
    end
  endtask

  task automatic do_reset(string tag);
    rst = 1'b1;
    run(tag, 2);
    rst = 1'b0;
  endtask

  // Monitor: compares one queued prediction per clock edge.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        e = sbq.pop_front();
        n_run++;
        if (q_e !== {2{e.v[0]}} || z_e !== e.z[0]) begin
          n_fail++;
          $display("FAIL %s even bank: q=%b oe_n=%b expected q=%b oe_n=%b",
                   e.tag, q_e, z_e, {2{e.v[0]}}, e.z[0]);
        end
        n_run++;
        if (q_o !== {2{e.v[1]}} || z_o !== e.z[1]) begin
          n_fail++;
          $display("FAIL %s odd bank: q=%b oe_n=%b expected q=%b oe_n=%b",
                   e.tag, q_o, z_o, {2{e.v[1]}}, e.z[1]);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    run("R1 reset state", 3);
    rst = 1'b0;
    run("R2 R11 div1 slow range", 40);
    div_sel = 6'd3; do_reset("R1"); run("R2 div3 slow range", 100);
    fast_rng = 1'b1; do_reset("R1"); run("R3 div3 fast range", 60);
    div_sel = 6'd1; do_reset("R1"); run("R3 div1 fast range", 30);
    fast_rng = 1'b0;
    div_sel = 6'd0; do_reset("R1"); run("R4 div0 acts as 1", 40);
    div_sel = 6'd40; do_reset("R1"); run("R4 div40 acts as 32", 1100);
    div_sel = 6'd2; inv_en = 1'b1; do_reset("R1"); run("R5 inverted div2", 70);
    inv_en = 1'b0;
    skew = 4'd2; do_reset("R1"); run("R6 skew +2", 70);
    skew = 4'hE; do_reset("R1"); run("R6 skew -2", 70);
    skew = 4'hF; fast_rng = 1'b1; do_reset("R1"); run("R6 skew -1 fast", 40);
    fast_rng = 1'b0;
    skew = 4'd3; do_reset("R1"); run("R7 skew 3 parity", 70);
    skew = 4'd6; do_reset("R1"); run("R7 skew 6 parity", 70);
    skew = 4'hA; do_reset("R1"); run("R7 skew -6 parity", 70);
    skew = 4'hD; do_reset("R1"); run("R7 skew -3 parity", 70);
    skew = 4'd7; do_reset("R1"); run("R7 skew 7 illegal", 40);
    skew = 4'h8; do_reset("R1"); run("R7 skew -8 illegal", 40);
    skew = 4'd3; div_sel = 6'd1; do_reset("R1");
    run("R8 enabled", 5);
    out_en = 1'b0; run("R8 disable mid-cycle", 37);
    out_en = 1'b1; run("R8 enable mid-cycle", 45);
    out_en = 1'b0; dis_mode = 2'd1; run("R9 hold high", 40);
    dis_mode = 2'd2; run("R9 high-Z", 20);
    dis_mode = 2'd3; run("R9 mode 3 low", 20);
    dis_mode = 2'd0; run("R9 hold low", 20);
    out_en = 1'b1; skew = 4'd0; div_sel = 6'd3; do_reset("R1");
    run("R10 before realign", 13);
    do_reset("R10 reset pulse");
    run("R10 after realign", 60);
    repeat (3) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule